// File: doc/BRIEF.md
# Status LED Pattern Generator

This block drives one status LED with a blink pattern that tells an observer which state a debug probe is in. A four-bit state code selects one of ten patterns. Some are "mostly on" with short dark gaps, some are "mostly off" with short flashes, and some are steady square waves or flicker. All timing comes from a millisecond tick. The block makes that tick itself by dividing the system clock, whose frequency is a parameter.

Each pattern runs on a 1000 ms frame. The state code is sampled only when a frame wraps, so a state change never cuts a pulse short. A synchronous reset forces the no-target pattern for the first frame. The chooser of the state, the LED current drive and any board-level polarity are handled elsewhere. The output is active high: 1 means the LED is lit.

Top module: `led_status_pattern`

## Requirements
- R1: While rst_i is high, led_o is 0 on the clock after each reset edge. The first frame after reset shows the no-target pattern (code 0), whatever state_i holds.
- R2: Code 0 (no target) gives 5 Hz: lit for frame ms 0 to 99, dark for 100 to 199, repeating every 200 ms.
- R3: Codes 1, 2 and 3 (the two debug-link connections and mass-storage active) keep the LED lit, except for dark gaps of 100 ms. Code 1 has one gap starting at ms 0. Code 2 has gaps starting at ms 0 and 500. Code 3 has gaps starting at ms 0, 333 and 666.
- R4: Codes 4, 5 and 6 (target found, control block found, data received) keep the LED dark, except for 20 ms flashes. The flashes start at the same points as in R3: one, two or three per frame.
- R5: Code 7 (serial traffic seen) keeps the LED lit for ms 0 to 299 of each frame and dark for the other 700 ms.
- R6: Code 8 (capture running) flashes at 10 Hz: lit for the first 50 ms of each 100 ms slot and dark for the rest.
- R7: Code 9 (capture waiting for trigger) gives a negative flicker at 10 Hz: dark for the first 20 ms of each 100 ms slot and lit for the other 80 ms.
- R8: Codes 10 to 15 keep led_o at 0 for the whole frame.
- R9: state_i is sampled only on the clock edge where the frame counter wraps from ms 999 to ms 0. Changes at any other time, even short pulses, have no effect on the current frame.
- R10: One millisecond is CLK_FREQ_HZ/1000 clock cycles. led_o follows the frame position with one register of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| state_i | input | 4 | Probe state code (0..9 defined, 10..15 dark) |
| led_o | output | 1 | LED drive, 1 = lit |

## Verification
The bench compares led_o on every clock cycle against an arithmetic model of millisecond position and frame number. It steps through every one of the 16 codes, frame by frame. Each state is loaded mid-frame and then followed by a one-cycle glitch to an undefined code. This shows that only the value present at the wrap is taken (R9), and it separates the three pulse counts and the on/off polarity of each family. Exact cycle comparison at the ms 299/300 and 99/100 edges checks the tick division and the one-cycle output lag. The reset frame, run with a non-zero code on state_i, checks that reset forces the no-target pattern.

// File: rtl/led_pat_pkg.sv
package led_pat_pkg;

  typedef enum logic [3:0] {
    ST_NO_TARGET = 4'd0,
    ST_LINK_A    = 4'd1,
    ST_LINK_B    = 4'd2,
    ST_STORAGE   = 4'd3,
    ST_TGT_SEEN  = 4'd4,
    ST_CB_SEEN   = 4'd5,
    ST_RX_DATA   = 4'd6,
    ST_SERIAL    = 4'd7,
    ST_CAPTURE   = 4'd8,
    ST_ARMED     = 4'd9
  } led_code_e;

  localparam int MAX_PULSES = 3;
  localparam int MS_PER_SEC = 1000;

endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      logic [CW-1:0] cnt_q;
      assign tick_o = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/led_phase_ctr.sv
module led_phase_ctr #(
  parameter int PERIOD_MS = 1000,
  parameter int PH_W      = 10
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            tick_i,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  logic last_ms;
  assign last_ms = (phase_o == PH_W'(PERIOD_MS - 1));
  assign wrap_o  = tick_i && last_ms;

  always_ff @(posedge clk_i) begin
    if (rst_i)       phase_o <= '0;
    else if (wrap_o) phase_o <= '0;
    else if (tick_i) phase_o <= phase_o + 1'b1;
  end
endmodule

// File: rtl/led_pat_decode.sv
module led_pat_decode
  import led_pat_pkg::*;
#(
  parameter int PERIOD_MS    = 1000,
  parameter int GAP_MS       = 100,
  parameter int FLASH_MS     = 20,
  parameter int SERIAL_ON_MS = 300,
  parameter int SLOW_MS      = 200,
  parameter int FAST_MS      = 100,
  parameter int PH_W         = 10
) (
  input  logic [3:0]      code_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            level_o
);
  int ph;
  assign ph = int'(phase_i);

  logic [MAX_PULSES-1:0] gap_hit   [MAX_PULSES];
  logic [MAX_PULSES-1:0] flash_hit [MAX_PULSES];
  logic [MAX_PULSES-1:0] in_gap, in_flash;

  // Row c holds the windows of the (c+1)-pulse patterns, evenly spread.
  for (genvar c = 0; c < MAX_PULSES; c++) begin : g_cnt
    for (genvar i = 0; i < MAX_PULSES; i++) begin : g_slot
      localparam int START = (PERIOD_MS * i) / (c + 1);
      if (i <= c) begin : g_on
        assign gap_hit[c][i]   = (ph >= START) && (ph < START + GAP_MS);
        assign flash_hit[c][i] = (ph >= START) && (ph < START + FLASH_MS);
      end else begin : g_off
        assign gap_hit[c][i]   = 1'b0;
        assign flash_hit[c][i] = 1'b0;
      end
    end
    assign in_gap[c]   = |gap_hit[c];
    assign in_flash[c] = |flash_hit[c];
  end

  always_comb begin
    case (code_i)
      ST_NO_TARGET: level_o = (ph % SLOW_MS) < (SLOW_MS / 2);
      ST_LINK_A:    level_o = !in_gap[0];
      ST_LINK_B:    level_o = !in_gap[1];
      ST_STORAGE:   level_o = !in_gap[2];
      ST_TGT_SEEN:  level_o = in_flash[0];
      ST_CB_SEEN:   level_o = in_flash[1];
      ST_RX_DATA:   level_o = in_flash[2];
      ST_SERIAL:    level_o = ph < SERIAL_ON_MS;
      ST_CAPTURE:   level_o = (ph % FAST_MS) < (FAST_MS / 2);
      ST_ARMED:     level_o = (ph % FAST_MS) >= FLASH_MS;
      default:      level_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/led_status_pattern.sv
module led_status_pattern
  import led_pat_pkg::*;
#(
  parameter int CLK_FREQ_HZ  = 125000000,
  parameter int PERIOD_MS    = 1000,
  parameter int GAP_MS       = 100,
  parameter int FLASH_MS     = 20,
  parameter int SERIAL_ON_MS = 300,
  parameter int SLOW_MS      = 200,
  parameter int FAST_MS      = 100
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [3:0] state_i,
  output logic       led_o
);
  localparam int TICK_DIV = CLK_FREQ_HZ / MS_PER_SEC;
  localparam int PH_W     = $clog2(PERIOD_MS);

  logic            ms_tick;
  logic            period_wrap;
  logic [PH_W-1:0] phase_q;
  logic [3:0]      code_q;
  logic            level;

  led_ms_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_o(ms_tick)
  );

  led_phase_ctr #(.PERIOD_MS(PERIOD_MS), .PH_W(PH_W)) u_phase (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (ms_tick),
    .phase_o(phase_q),
    .wrap_o (period_wrap)
  );

  // The state code only moves at a frame wrap, so a pulse is never truncated.
  always_ff @(posedge clk_i) begin
    if (rst_i)            code_q <= ST_NO_TARGET;
    else if (period_wrap) code_q <= state_i;
  end

  led_pat_decode #(
    .PERIOD_MS   (PERIOD_MS),
    .GAP_MS      (GAP_MS),
    .FLASH_MS    (FLASH_MS),
    .SERIAL_ON_MS(SERIAL_ON_MS),
    .SLOW_MS     (SLOW_MS),
    .FAST_MS     (FAST_MS),
    .PH_W        (PH_W)
  ) u_dec (
    .code_i (code_q),
    .phase_i(phase_q),
    .level_o(level)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) led_o <= 1'b0;
    else       led_o <= level;
  end
endmodule

// File: rtl/led_status_checker.sv
module led_status_checker #(
  parameter int PERIOD_MS    = 1000,
  parameter int TICK_DIV     = 4,
  parameter int GAP_MS       = 100,
  parameter int SERIAL_ON_MS = 300,
  parameter int PH_W         = 10
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic [3:0]      code_q,
  input logic [PH_W-1:0] phase_q,
  input logic            ms_tick,
  input logic            period_wrap,
  input logic            led_o
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk_i) rst_d <= rst_i;

  // R1: the clock after a reset edge leaves the LED dark
  always @(negedge clk_i) begin
    if (rst_d) p_reset_dark_r1: assert (!led_o);
  end

  // R9: code changes only at a frame wrap
  p_code_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !period_wrap |=> $stable(code_q));

  // R10: frame position stays inside the frame
  p_phase_range_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(phase_q) < PERIOD_MS);

  // R10: millisecond ticks are never back to back when the divider exceeds one
  if (TICK_DIV > 1) begin : g_tick_chk
    p_tick_gap_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      ms_tick |=> !ms_tick);
  end

  // R8: undefined codes keep the LED dark
  p_undef_dark_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q >= 4'd10) |=> !led_o);

  // R3: link and storage patterns are lit between the first and second gap
  p_link_lit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q >= 4'd1 && code_q <= 4'd3 &&
     int'(phase_q) >= 2 * GAP_MS && int'(phase_q) < 3 * GAP_MS) |=> led_o);

  // R4: discovery patterns are dark in the last quarter of the frame
  p_flash_tail_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q >= 4'd4 && code_q <= 4'd6 &&
     int'(phase_q) >= (PERIOD_MS * 3) / 4) |=> !led_o);

  // R5: serial pattern lit in its on window
  p_serial_on_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q == 4'd7 && int'(phase_q) < SERIAL_ON_MS) |=> led_o);
endmodule

bind led_status_pattern led_status_checker #(
  .PERIOD_MS   (PERIOD_MS),
  .TICK_DIV    (TICK_DIV),
  .GAP_MS      (GAP_MS),
  .SERIAL_ON_MS(SERIAL_ON_MS),
  .PH_W        (PH_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .code_q     (code_q),
  .phase_q    (phase_q),
  .ms_tick    (ms_tick),
  .period_wrap(period_wrap),
  .led_o      (led_o)
);

// File: tb/led_status_pattern_test.sv
module led_status_pattern_test;
  localparam int DIV  = 4;
  localparam int PER  = 1000;
  localparam int NPER = 19;
  localparam int CYC  = DIV * PER;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] st  = 4'd5;
  logic       led;
  bit         done = 1'b0;
  int         checks = 0;
  int         fails  = 0;

  // code in effect per frame; frame 0 is forced to code 0 by reset
  int codes [NPER] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 0, 10, 11, 12, 13, 14, 15, 6, 0};

  always #2.5 clk = ~clk;

  led_status_pattern #(.CLK_FREQ_HZ(DIV * 1000)) uut (
    .clk_i  (clk),
    .rst_i  (rst),
    .state_i(st),
    .led_o  (led)
  );

  function automatic bit win(int ms, int s, int w);
    return (ms >= s) && (ms < s + w);
  endfunction

  function automatic bit exp_led(int c, int ms);
    case (c)
      0: return (ms % 200) < 100;
      1: return !win(ms, 0, 100);
      2: return !(win(ms, 0, 100) || win(ms, 500, 100));
      3: return !(win(ms, 0, 100) || win(ms, 333, 100) || win(ms, 666, 100));
      4: return win(ms, 0, 20);
      5: return win(ms, 0, 20) || win(ms, 500, 20);
      6: return win(ms, 0, 20) || win(ms, 333, 20) || win(ms, 666, 20);
      7: return ms < 300;
      8: return (ms % 100) < 50;
      9: return (ms % 100) >= 20;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(int c);
    case (c)
      0:       return "R2";
      1, 2, 3: return "R3";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R6";
      9:       return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit got, bit exp, string req, int n);
    checks++;
    if (got !== exp) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s cycle %0d led actual %0b expected %0b", req, n, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(led, 1'b0, "R1", -i);
    end
    rst = 1'b0;
    for (int n = 1; n <= NPER * CYC; n++) begin
      int p, k, ms, c;
      string req;
      @(negedge clk);
      p  = (n - 1) / DIV;
      k  = p / PER;
      ms = p % PER;
      c  = codes[k];
      if (k == 0)                                 req = "R1";
      else if (ms < 2)                            req = "R9";
      else if (c == 7 && (ms == 299 || ms == 300)) req = "R10";
      else                                        req = req_of(c);
      check(led, exp_led(c, ms), req, n);
      // load next frame's code mid-frame, then a one-cycle glitch (R9)
      if (k + 1 < NPER) begin
        if (n % CYC == 1600)      st = 4'(codes[k + 1]);
        else if (n % CYC == 2800) st = 4'd12;
        else if (n % CYC == 2801) st = 4'(codes[k + 1]);
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule